// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block sits on the cartridge side of an 8-bit CPU bus. It watches CPU writes to the upper half of the address space and keeps a small set of control registers. These are a bank-select index, a file of bank data registers, a nametable mirroring bit and a work-RAM control field. From these registers it turns the CPU address into an 8 KB program bank number, and the picture-unit pattern address into a 1 KB pattern bank number. Both translations are purely combinational, so the ROM address bits follow the incoming address in the same cycle.

Two bits of the index register change the translation. One bit swaps the placement of the two even program windows. The other bit exchanges the 2 KB-paired half of pattern space with the 1 KB half. The last two program banks are always reachable through fixed windows. The scanline interrupt counter that shares the $C000-$FFFF range lives in a separate block, so this block ignores writes there.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write is decoded from address bits 15, 14, 13 and 0 alone. {A15,A14,A13,A0} = 1000 writes the index, 1001 writes a data register, 1010 writes mirroring and 1011 writes RAM control. Every other write, including those below $8000 and those at $C000-$FFFF, changes no output.
- R2: A data write goes to the register whose number is the index value ANDed with (REG_COUNT-1). For example, index $0E with the default count of 8 selects register 6.
- R3: The program window is cpuAddr[14:13]. With index bit 6 clear, window 0 gives register 6, window 1 gives register 7, window 2 gives bank $FE and window 3 gives bank $FF.
- R4: With index bit 6 set, window 0 gives bank $FE and window 2 gives register 6. Windows 1 and 3 are unchanged.
- R5: The pattern window is ppuAddr[12:10]. With index bit 7 clear, windows 0 and 1 give register 0, and windows 2 and 3 give register 1, in each case with bit 0 replaced by the window's bit 0. Windows 4 to 7 give registers 2 to 5.
- R6: With index bit 7 set, the pattern window number is XORed with 4 before it is translated.
- R7: A synchronous active-high reset loads registers 0 to 7 with 0, 2, 4, 5, 6, 7, 0, 1. It also clears the index, mirroring and RAM control.
- R8: mirrorHorz equals bit 0 of the last mirroring write (1 = horizontal, 0 = vertical).
- R9: wramEnable equals bit 7 of the last RAM-control write. wramWritable is high only when bit 7 is set and bit 6 is clear.
- R10: A register write takes effect at the clock edge that samples the strobe and not before. Bank outputs follow a change of address in the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWrEn | input | 1 | CPU write strobe, one cycle per write |
| ppuAddr | input | 13 | Pattern-space address |
| prgBank | output | 8 | Physical program bank for cpuAddr |
| chrBank | output | 8 | Physical pattern bank for ppuAddr |
| mirrorHorz | output | 1 | Nametable mirroring select, 1 = horizontal |
| wramEnable | output | 1 | Work RAM at $6000-$7FFF enabled |
| wramWritable | output | 1 | Work RAM writes allowed |

## Verification
The registers have no read path, so any wrong internal state shows up only through the translation outputs. The bench therefore sweeps all four program windows and all eight pattern windows after each write. A wrongly written data register or mode bit shows up on the very next probe, in the cycle after the write edge. A mis-decoded alias or a write that leaks from $C000-$FFFF shows up as a changed bank or control output, even though nothing was meant to change.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  // One-cycle write strobes from the decoder to the register datapath
  typedef struct packed {
    logic wrIndex;
    logic wrData;
    logic wrMirror;
    logic wrRamCtl;
  } mapStrobe_t;

  // Power-on contents of the bank data registers
  function automatic int bootValue(int regNum);
    case (regNum)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 5;
      4: return 6;
      5: return 7;
      6: return 0;
      7: return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cart_map_ctrl.sv
module cart_map_ctrl
  import cart_map_pkg::*;
(
  input  logic [15:0] cpuAddr,
  input  logic        cpuWrEn,
  output mapStrobe_t  strb
);

  logic unusedAddr;
  assign unusedAddr = ^cpuAddr[12:1];

  logic inRange;
  assign inRange = cpuWrEn && cpuAddr[15] && !cpuAddr[14];

  always_comb begin
    strb = '0;
    if (inRange) begin
      case ({cpuAddr[13], cpuAddr[0]})
        2'b00: strb.wrIndex  = 1'b1;
        2'b01: strb.wrData   = 1'b1;
        2'b10: strb.wrMirror = 1'b1;
        default: strb.wrRamCtl = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cart_map_datapath.sv
module cart_map_datapath
  import cart_map_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 8,   // power of two, at least 8
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  mapStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        cpuWin,
  input  logic [2:0]        ppuWin,
  output logic [DATA_W-1:0] prgBank,
  output logic [DATA_W-1:0] chrBank,
  output logic              mirrorHorz,
  output logic              wramEnable,
  output logic              wramWritable
);

  localparam logic [IDX_W-1:0]  SEL_MASK = IDX_W'(REG_COUNT - 1);
  localparam logic [DATA_W-1:0] LAST_BANK = '1;

  logic [IDX_W-1:0] selReg;
  logic             prgSwap;
  logic             chrInvert;
  logic             mirrorBit;
  logic             ramOn;
  logic             ramLock;

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg    <= '0;
      prgSwap   <= 1'b0;
      chrInvert <= 1'b0;
      mirrorBit <= 1'b0;
      ramOn     <= 1'b0;
      ramLock   <= 1'b0;
    end else begin
      if (strb.wrIndex) begin
        selReg    <= wrData[IDX_W-1:0] & SEL_MASK;
        prgSwap   <= wrData[6];
        chrInvert <= wrData[7];
      end
      if (strb.wrMirror) mirrorBit <= wrData[0];
      if (strb.wrRamCtl) begin
        ramOn   <= wrData[7];
        ramLock <= wrData[6];
      end
    end
  end

  // Bank data register file
  logic [DATA_W-1:0] bankReg [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : gBank
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= DATA_W'(bootValue(g));
      else if (strb.wrData && selReg == IDX_W'(g))
        q <= wrData;
    end
    assign bankReg[g] = q;
  end

  // Program window translation
  logic [1:0] prgWin;
  always_comb begin
    prgWin = cpuWin;
    if (prgSwap && !prgWin[0]) prgWin[1] = ~prgWin[1];
    if (prgWin[1])
      prgBank = prgWin[0] ? LAST_BANK : LAST_BANK - 1'b1;
    else
      prgBank = prgWin[0] ? bankReg[7] : bankReg[6];
  end

  // Pattern window translation
  logic [2:0]        chrWin;
  logic [DATA_W-1:0] pairBase;
  always_comb begin
    chrWin   = ppuWin ^ {chrInvert, 2'b00};
    pairBase = chrWin[1] ? bankReg[1] : bankReg[0];
    if (chrWin[2]) begin
      case (chrWin[1:0])
        2'd0:    chrBank = bankReg[2];
        2'd1:    chrBank = bankReg[3];
        2'd2:    chrBank = bankReg[4];
        default: chrBank = bankReg[5];
      endcase
    end else begin
      chrBank = {pairBase[DATA_W-1:1], chrWin[0]};
    end
  end

  assign mirrorHorz   = mirrorBit;
  assign wramEnable   = ramOn;
  assign wramWritable = ramOn && !ramLock;

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              cpuWrEn,
  input  logic [12:0]       ppuAddr,
  output logic [DATA_W-1:0] prgBank,
  output logic [DATA_W-1:0] chrBank,
  output logic              mirrorHorz,
  output logic              wramEnable,
  output logic              wramWritable
);

  mapStrobe_t strb;
  logic       unusedPpu;
  assign unusedPpu = ^ppuAddr[9:0];

  cart_map_ctrl ctrl_i (
    .cpuAddr (cpuAddr),
    .cpuWrEn (cpuWrEn),
    .strb    (strb)
  );

  cart_map_datapath #(
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT)
  ) dp_i (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .wrData       (cpuData),
    .cpuWin       (cpuAddr[14:13]),
    .ppuWin       (ppuAddr[12:10]),
    .prgBank      (prgBank),
    .chrBank      (chrBank),
    .mirrorHorz   (mirrorHorz),
    .wramEnable   (wramEnable),
    .wramWritable (wramWritable)
  );

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpuAddr,
  input logic [DATA_W-1:0] cpuData,
  input logic              cpuWrEn,
  input logic [DATA_W-1:0] prgBank,
  input logic              mirrorHorz,
  input logic              wramEnable,
  input logic              wramWritable
);

  logic mirWr, ramWr;
  assign mirWr = cpuWrEn && ((cpuAddr & 16'hE001) == 16'hA000);
  assign ramWr = cpuWrEn && ((cpuAddr & 16'hE001) == 16'hA001);

  AST_TOP_WINDOW_FIXED: assert property (@(posedge clk) disable iff (rst)
    (cpuAddr[14:13] == 2'b11) |-> (prgBank == '1)); // R3

  AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (rst)
    mirWr |=> (mirrorHorz == $past(cpuData[0]))); // R8

  AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mirWr |=> $stable(mirrorHorz)); // R1

  AST_RAM_LOAD: assert property (@(posedge clk) disable iff (rst)
    ramWr |=> (wramEnable == $past(cpuData[7])) &&
              (wramWritable == $past(cpuData[7] && !cpuData[6]))); // R9

  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    wramWritable |-> wramEnable); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!mirrorHorz && !wramEnable)); // R7

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cpuAddr      (cpuAddr),
  .cpuData      (cpuData),
  .cpuWrEn      (cpuWrEn),
  .prgBank      (prgBank),
  .mirrorHorz   (mirrorHorz),
  .wramEnable   (wramEnable),
  .wramWritable (wramWritable)
);

// File: tb/cart_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  cpuData = 8'h00;
  logic        cpuWrEn = 1'b0;
  logic [12:0] ppuAddr = 13'h0000;
  logic [7:0]  prgBank, chrBank;
  logic        mirrorHorz, wramEnable, wramWritable;

  always #2.5 clk = ~clk;

  cart_bank_mapper dut_i (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWrEn(cpuWrEn), .ppuAddr(ppuAddr), .prgBank(prgBank),
    .chrBank(chrBank), .mirrorHorz(mirrorHorz), .wramEnable(wramEnable),
    .wramWritable(wramWritable)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Reference model state, built from the requirements
  logic [7:0] mIdx;
  logic [7:0] mReg [8];
  logic       mMirror;
  logic [7:0] mRam;

  task automatic modelReset();
    mIdx = 0; mMirror = 0; mRam = 0;
    mReg[0] = 8'd0; mReg[1] = 8'd2; mReg[2] = 8'd4; mReg[3] = 8'd5;
    mReg[4] = 8'd6; mReg[5] = 8'd7; mReg[6] = 8'd0; mReg[7] = 8'd1;
  endtask

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expPrg(logic [1:0] w);
    logic [1:0] v = w;
    if (mIdx[6] && !v[0]) v[1] = ~v[1];
    if (v[1]) return {7'h7F, v[0]};
    return v[0] ? mReg[7] : mReg[6];
  endfunction

  function automatic logic [7:0] expChr(logic [2:0] w);
    logic [2:0] v = w ^ {mIdx[7], 2'b00};
    logic [7:0] b;
    if (v[2]) return mReg[2 + int'(v[1:0])];
    b = mReg[int'(v[1])];
    return {b[7:1], v[0]};
  endfunction

  task automatic cpuWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
    if (a[15] && !a[14]) begin
      case ({a[13], a[0]})
        2'b00: mIdx = d;
        2'b01: mReg[mIdx & 8'h07] = d;
        2'b10: mMirror = d[0];
        default: mRam = d;
      endcase
    end
  endtask

  task automatic checkAll(string req);
    for (int w = 0; w < 4; w++) begin
      cpuAddr = 16'h8000 | 16'(w << 13);
      #0.5;
      check(req, $sformatf("prg win %0d", w), prgBank, expPrg(2'(w)));
    end
    for (int w = 0; w < 8; w++) begin
      ppuAddr = 13'(w << 10) | 13'h015;
      #0.5;
      check(req, $sformatf("chr win %0d", w), chrBank, expChr(3'(w)));
    end
    check(req, "mirror", {7'd0, mirrorHorz}, {7'd0, mMirror});
    check(req, "wramEnable", {7'd0, wramEnable}, {7'd0, mRam[7]});
    check(req, "wramWritable", {7'd0, wramWritable}, {7'd0, mRam[7] & ~mRam[6]});
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    modelReset();
  endtask

  // R7: power-on values
  task automatic testReset();
    doReset();
    checkAll("R7");
  endtask

  // R3 / R4: program window placement in both modes
  task automatic testPrg();
    cpuWrite(16'h8000, 8'h06); cpuWrite(16'h8001, 8'h23);
    cpuWrite(16'h8000, 8'h07); cpuWrite(16'h8001, 8'h41);
    checkAll("R3");
    cpuWrite(16'h8000, 8'h46);
    checkAll("R4");
    cpuWrite(16'h8000, 8'h40); cpuWrite(16'h8001, 8'h3C);
    checkAll("R4");
  endtask

  // R5 / R6: pattern windows, odd pair values to prove bit 0 replacement
  task automatic testChr();
    cpuWrite(16'h8000, 8'h00); cpuWrite(16'h8001, 8'h11);
    cpuWrite(16'h8000, 8'h01); cpuWrite(16'h8001, 8'h2B);
    cpuWrite(16'h8000, 8'h02); cpuWrite(16'h8001, 8'hA0);
    cpuWrite(16'h8000, 8'h03); cpuWrite(16'h8001, 8'hA1);
    cpuWrite(16'h8000, 8'h04); cpuWrite(16'h8001, 8'hB2);
    cpuWrite(16'h8000, 8'h05); cpuWrite(16'h8001, 8'hC3);
    checkAll("R5");
    cpuWrite(16'h8000, 8'h80);
    checkAll("R6");
    cpuWrite(16'h8000, 8'hC0);
    checkAll("R6");
  endtask

  // R1 / R2: aliases, index masking and ignored ranges
  task automatic testDecode();
    cpuWrite(16'h9FFE, 8'h0E);
    cpuWrite(16'h8003, 8'h55);
    checkAll("R2");
    cpuWrite(16'h9F12, 8'h07);
    cpuWrite(16'h9FFF, 8'h9A);
    checkAll("R1");
    cpuWrite(16'hC000, 8'hFF); cpuWrite(16'hC001, 8'hFF);
    cpuWrite(16'hE000, 8'hFF); cpuWrite(16'hE001, 8'hFF);
    cpuWrite(16'h6000, 8'hFF); cpuWrite(16'h7FFF, 8'hFF);
    cpuWrite(16'h0001, 8'hFF);
    checkAll("R1");
  endtask

  // R8: mirroring through aliases
  task automatic testMirror();
    cpuWrite(16'hA000, 8'h01); checkAll("R8");
    cpuWrite(16'hBFFE, 8'hFE); checkAll("R8");
    cpuWrite(16'hA002, 8'h03); checkAll("R8");
  endtask

  // R9: RAM control combinations
  task automatic testRam();
    cpuWrite(16'hA001, 8'h80); checkAll("R9");
    cpuWrite(16'hA001, 8'hC0); checkAll("R9");
    cpuWrite(16'hBFFF, 8'h40); checkAll("R9");
    cpuWrite(16'hA001, 8'hBF); checkAll("R9");
  endtask

  // R10: write takes effect at the sampling edge; outputs follow address at once
  task automatic testTiming();
    cpuWrite(16'hA000, 8'h00); mMirror = 0;
    @(negedge clk);
    cpuAddr = 16'hA000; cpuData = 8'h01; cpuWrEn = 1'b1;
    #1;
    check("R10", "mirror before edge", {7'd0, mirrorHorz}, 8'd0);
    @(posedge clk); #1;
    check("R10", "mirror after edge", {7'd0, mirrorHorz}, 8'd1);
    @(negedge clk); cpuWrEn = 1'b0; mMirror = 1;
    cpuAddr = 16'hE000; #0.5;
    check("R10", "prg follows addr", prgBank, expPrg(2'd3));
    cpuAddr = 16'hA000; #0.5;
    check("R10", "prg follows addr", prgBank, expPrg(2'd1));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    modelReset();
    testReset();
    testPrg();
    testChr();
    testDecode();
    testMirror();
    testRam();
    testTiming();
    testReset();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule